// File: doc/BRIEF.md
# Two-Level Hybrid Carry Adder

This block is a purely combinational 8-bit binary adder. It adds two operands and a single carry-in bit and returns an 8-bit sum together with a carry-out. There is no clock, no reset and no internal state. A change on any input shows on the outputs as soon as the logic settles.

The adder is split into two 4-bit sections. Each section works out every bit's generate term (both operand bits set) and propagate term (operand bits differ). From these and the section's incoming carry, it forms every internal carry at once as a flat sum of products. The low section takes the external carry-in. Its carry-out becomes the incoming carry of the high section, which supplies the external carry-out.

The result is a middle point between a flat ripple chain and a full lookahead tree. Lookahead logic stays inside each nibble, and only one carry hop crosses between nibbles.

Top module: `hybrid_carry_adder`

## Requirements
- R1: For every combination of `a`, `b` and `cin`, the concatenation {`cout`, `sum`} equals the unsigned value `a` + `b` + `cin`.
- R2: The block holds no state. `sum` and `cout` follow a change on any input without any clock edge, and earlier inputs have no effect on the result.
- R3: The carry from the low nibble into the high nibble equals bit 4 of `a[3:0]` + `b[3:0]` + `cin`. As a result, `sum[7:4]` equals (`a[7:4]` + `b[7:4]` + that carry) mod 16.
- R4: `sum[3:0]` equals (`a[3:0]` + `b[3:0]` + `cin`) mod 16 and does not depend on `a[7:4]` or `b[7:4]`.
- R5: When every bit of a section propagates (its operand nibbles are bitwise complements), the section's carry-out equals its carry-in. For example, `a`=0xFF, `b`=0x00 gives `cout` = `cin`.
- R6: When no bit of a section generates and not every bit propagates, the section's carry-out is 0, whatever its carry-in.
- R7: `cout` is the carry-out of the high section. It equals bit 4 of `a[7:4]` + `b[7:4]` + the carry from the low nibble. For example, 0x80 + 0x80 with `cin`=0 gives `cout`=1 and `sum`=0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | First unsigned operand |
| b | input | 8 | Second unsigned operand |
| cin | input | 1 | Carry-in to the least significant bit |
| sum | output | 8 | Sum modulo 256 |
| cout | output | 1 | Carry-out from the most significant bit |

## Verification
Immediate assertions check the following whenever the inputs change:
- each section's arithmetic;
- the pass-through and kill rules on a section's carry-out;
- the carry between the nibbles;
- the full 8-bit result.

These checks all work at nibble and word level. The bench sweeps all 131072 input combinations against an arithmetic reference and adds directed patterns aimed at the carry boundaries. Only the bench shows two things: that the result never depends on the previous inputs, and that a changed upper nibble leaves the lower sum untouched.

// File: rtl/hca_pkg.sv
package hca_pkg;
    // Default operand width and lookahead section width.
    localparam int unsigned HCA_WIDTH = 8;
    localparam int unsigned HCA_SEC_W = 4;

    // Per-bit carry terms.
    typedef struct packed {
        logic gen;
        logic prop;
    } pg_t;
endpackage

// File: rtl/hca_pg_cell.sv
module hca_pg_cell
    import hca_pkg::*;
(
    input  logic x,
    input  logic y,
    output pg_t  pg
);
    always_comb begin
        pg.gen  = x & y;
        pg.prop = x ^ y;
    end
endmodule

// File: rtl/hca_section.sv
module hca_section
    import hca_pkg::*;
#(
    parameter int unsigned SEC_W = HCA_SEC_W
) (
    input  logic [SEC_W-1:0] x,
    input  logic [SEC_W-1:0] y,
    input  logic             c_in,
    output logic [SEC_W-1:0] s,
    output logic             c_out
);
    logic [SEC_W-1:0] g_v;
    logic [SEC_W-1:0] p_v;
    logic [SEC_W:0]   c_v;

    for (genvar k = 0; k < SEC_W; k++) begin : g_bit
        pg_t pg_k;
        hca_pg_cell u_pg (.x(x[k]), .y(y[k]), .pg(pg_k));
        assign g_v[k] = pg_k.gen;
        assign p_v[k] = pg_k.prop;
    end

    // Each carry is one flat sum of products over g, p and c_in.
    // No carry is built from the carry below it.
    always_comb begin
        c_v[0] = c_in;
        for (int i = 0; i < SEC_W; i++) begin
            logic acc;
            logic run;
            acc = 1'b0;
            run = 1'b1;
            for (int j = i; j >= 0; j--) begin
                acc = acc | (run & g_v[j]);
                run = run & p_v[j];
            end
            c_v[i+1] = acc | (run & c_in);
        end
    end

    assign s     = p_v ^ c_v[SEC_W-1:0];
    assign c_out = c_v[SEC_W];

    // Reference value for the checks below.
    logic [SEC_W:0] ref_v;
    assign ref_v = {1'b0, x} + {1'b0, y} + {{SEC_W{1'b0}}, c_in};

    always_comb begin
        // R1: the section's own arithmetic is exact.
        p_sec_sum_r1: assert ({c_out, s} == ref_v)
            else $error("section sum mismatch");
        // R5: a fully propagating section passes its carry through.
        if (&(x ^ y))
            p_pass_r5: assert (c_out == c_in)
                else $error("propagate pass-through broken");
        // R6: no generate and no full propagate means no carry out.
        if (((x & y) == '0) && !(&(x ^ y)))
            p_kill_r6: assert (c_out == 1'b0)
                else $error("carry out without generate");
    end
endmodule

// File: rtl/hybrid_carry_adder.sv
module hybrid_carry_adder
    import hca_pkg::*;
#(
    parameter int unsigned WIDTH = HCA_WIDTH,
    parameter int unsigned SEC_W = HCA_SEC_W
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned NUM_SEC = WIDTH / SEC_W;

    // link[k] is the carry into section k; link[NUM_SEC] leaves the block.
    logic [NUM_SEC:0] link;
    assign link[0] = cin;

    for (genvar k = 0; k < NUM_SEC; k++) begin : g_sec
        hca_section #(.SEC_W(SEC_W)) u_sec (
            .x     (a[k*SEC_W +: SEC_W]),
            .y     (b[k*SEC_W +: SEC_W]),
            .c_in  (link[k]),
            .s     (sum[k*SEC_W +: SEC_W]),
            .c_out (link[k+1])
        );
    end

    assign cout = link[NUM_SEC];

    logic [WIDTH:0] total_v;
    logic [SEC_W:0] low_v;
    assign total_v = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
    assign low_v   = {1'b0, a[SEC_W-1:0]} + {1'b0, b[SEC_W-1:0]}
                   + {{SEC_W{1'b0}}, cin};

    always_comb begin
        // R1: full-width result.
        p_total_r1: assert ({cout, sum} == total_v)
            else $error("total sum mismatch");
        // R3: the carry between the nibbles.
        p_midcarry_r3: assert (link[1] == low_v[SEC_W])
            else $error("inter-section carry mismatch");
        // R7: external carry-out.
        p_cout_r7: assert (cout == total_v[WIDTH])
            else $error("carry-out mismatch");
    end
endmodule

// File: tb/test_hybrid_carry_adder.sv
module test_hybrid_carry_adder;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a = '0;
    logic [7:0] b = '0;
    logic       cin = 1'b0;
    logic [7:0] sum;
    logic       cout;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    hybrid_carry_adder i_hybrid_carry_adder (
        .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
    );

    task automatic apply(input logic [7:0] ta, input logic [7:0] tb_v, input logic tc);
        a = ta; b = tb_v; cin = tc;
        #1;
    endtask

    task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s a=%h b=%h cin=%b actual=%h expected=%h", req, a, b, cin, act, exp);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Idle state: all-zero inputs give a zero result (R1).
        apply(8'h00, 8'h00, 1'b0);
        check("R1 zero", {cout, sum}, 9'h000);

        // R5: full propagate passes the carry through both sections.
        apply(8'hFF, 8'h00, 1'b1); check("R5 pass c=1", {cout, sum}, 9'h100);
        apply(8'hFF, 8'h00, 1'b0); check("R5 pass c=0", {cout, sum}, 9'h0FF);
        apply(8'hA5, 8'h5A, 1'b1); check("R5 pass alt", {cout, sum}, 9'h100);

        // R3: carry into the high nibble.
        apply(8'h0F, 8'h01, 1'b0); check("R3 mid carry", {1'b0, sum}, 9'h010);
        apply(8'h0F, 8'h00, 1'b1); check("R3 mid via cin", {1'b0, sum}, 9'h010);
        apply(8'h08, 8'h07, 1'b0); check("R3 no mid carry", {1'b0, sum}, 9'h00F);

        // R6: no generate and not full propagate -> no carry out.
        apply(8'h0E, 8'h00, 1'b1); check("R6 kill", {1'b0, sum}, 9'h00F);
        apply(8'h30, 8'h40, 1'b1); check("R6 kill high", {cout, sum}, 9'h071);

        // R7: carry-out of the high section.
        apply(8'h80, 8'h80, 1'b0); check("R7 msb carry", {cout, sum}, 9'h100);
        apply(8'hF0, 8'h10, 1'b0); check("R7 high gen", {cout, sum}, 9'h100);

        // R4: the low nibble ignores the upper operand bits.
        for (int hi = 0; hi < 256; hi++) begin
            apply({hi[3:0], 4'h9}, {hi[7:4], 4'h8}, 1'b1);
            check("R4 low nibble", {5'b0, sum[3:0]}, 9'h002);
        end

        // R2: the result does not depend on earlier inputs.
        apply(8'hFF, 8'hFF, 1'b1);
        apply(8'h01, 8'h02, 1'b0);
        check("R2 no memory", {cout, sum}, 9'h003);
        apply(8'h00, 8'h00, 1'b0);
        apply(8'h01, 8'h02, 1'b0);
        check("R2 no memory repeat", {cout, sum}, 9'h003);

        // R1: exhaustive sweep.
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                for (int ic = 0; ic < 2; ic++) begin
                    logic [8:0] exp_v;
                    exp_v = 9'(ia) + 9'(ib) + 9'(ic);
                    apply(ia[7:0], ib[7:0], ic[0]);
                    check("R1 sweep", {cout, sum}, exp_v);
                end
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule